// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Sequencer

This block sits on the system bus as a read-only slave. When the CPU reads from a fixed 1 MiB address window, the block runs a complete serial flash read on a 4-bit data bus and stalls the bus until the result is ready. Each read is a run of phases: an optional command byte, the flash address, an optional mode-byte/dummy stretch, and the data. The address, mode and data phases each use their own lane count of 1, 2 or 4. The flash address is the offset into the window plus a programmable remap base.

The block supports execute-in-place. When a read sends the "enter" mode byte in full, the flash stays in continuous-read mode and later reads start directly at the address phase. A terminate request makes the next read send the "exit" mode byte instead, and the read after that sends the command byte again. Results of 1, 2 or 4 bytes are assembled little-endian. A completed word read also raises a one-cycle DMA request.

The flash side runs one serial clock per system clock. `fl_sck_en` marks the cycles in which a serial clock is issued. The configuration inputs must be held stable while a read is in flight.

Top module: `xip_flash_reader`

## Requirements
- R1: A request is accepted only when `req_valid`, `cfg_enable` and `bus_ready` are all high and `req_addr` lies in [0x0008_0000, 0x0018_0000). Any other request starts nothing: `fl_cs_n` stays high and `bus_ready` stays high.
- R2: The flash address is `cfg_remap_base` + (`req_addr` − 0x0008_0000), keeping the low 20 bits of the difference. It is sent most significant bit first, as 32 bits when `cfg_addr4`=1 and as the low 24 bits when `cfg_addr4`=0.
- R3: When execute-in-place is not active, each read begins with `cfg_read_cmd`, sent over 8 clocks, MSB first, on line 0 only (`fl_io_oe`=0001). Bringing `cfg_enable` low clears execute-in-place, so the first read after re-enabling sends the command again.
- R4: The lane codes are 0 for one line, 1 for two lines and 2 or 3 for four lines. On each clock, lines [n-1:0] carry the next n bits of the phase, with the higher line carrying the more significant bit, and `fl_io_oe` equals the lane mask.
- R5: The mode phase lasts `cfg_mode_clks` clocks and is skipped when that value is 0. The mode byte is driven MSB first during the first 8/n clocks. During any remaining clocks all output enables are low.
- R6: The byte sent in the mode phase is `cfg_mode_enter` when `cfg_xip_en`=1 and no terminate is pending. Otherwise it is `cfg_mode_exit`. Execute-in-place state changes only when the whole byte fits, that is when `cfg_mode_clks`×n ≥ 8. It becomes active if the enter byte was sent, and while it is active the next read skips the command phase.
- R7: A one-cycle pulse on `xip_exit_req` marks a terminate as pending. The next read that fully sends a mode byte sends `cfg_mode_exit`, clears both execute-in-place and the pending terminate, and the read after it sends the command again.
- R8: The data phase reads 1, 2 or 4 bytes for `req_size` 0, 1 or 2/3. All output enables are low during this phase. Single-lane data is sampled on line 1, dual-lane data on lines [1:0] and quad-lane data on lines [3:0], each byte MSB first. The first byte lands in `rd_data[7:0]`, and unused upper bytes read as zero.
- R9: `bus_ready` is high only while idle. `rd_valid` is high for exactly one cycle, the cycle after the last data clock, with `fl_cs_n` high. The block is idle again in the following cycle. Requests made while not ready are ignored.
- R10: `dma_req` pulses together with `rd_valid` exactly when the read was 4 bytes.
- R11: `fl_cs_n` is low and `fl_sck_en` is high in exactly the serial clock cycles of the command, address, mode and data phases, with no gaps between phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows window decoding; low clears execute-in-place |
| cfg_addr4 | input | 1 | 1: 4-byte address, 0: 3-byte address |
| cfg_addr_lanes | input | 2 | Lane code of the address phase |
| cfg_mode_lanes | input | 2 | Lane code of the mode/dummy phase |
| cfg_data_lanes | input | 2 | Lane code of the data phase |
| cfg_mode_clks | input | MODE_CLK_W | Clock count of the mode/dummy phase |
| cfg_xip_en | input | 1 | Select the enter mode byte |
| cfg_read_cmd | input | 8 | Read command byte |
| cfg_mode_enter | input | 8 | Mode byte that keeps continuous read |
| cfg_mode_exit | input | 8 | Mode byte that leaves continuous read |
| cfg_remap_base | input | 32 | Added to the window offset |
| xip_exit_req | input | 1 | Pulse: request leaving execute-in-place |
| req_valid | input | 1 | Bus read request |
| req_addr | input | 32 | Bus byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_ready | output | 1 | High while idle and able to accept |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | 32 | Read result, valid with rd_valid |
| dma_req | output | 1 | Pulse on completion of a word read |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck_en | output | 1 | One serial clock in this cycle |
| fl_io_out | output | 4 | Flash data lines, driven values |
| fl_io_oe | output | 4 | Per-line output enable |
| fl_io_in | input | 4 | Flash data lines, sampled values |

## Verification
The bench builds the block with its default parameters: a 1 MiB window at 0x0008_0000 and a 4-bit mode clock count. These defaults put both window edges, 0x0007_FFFF and 0x0017_FFFF, within reach, and allow mode phases from 0 to 15 clocks. That range covers the skipped phase, a mode byte cut short, a byte that fits exactly, and a byte followed by dummy clocks, in every lane width. The bench also mixes lane widths across phases and both address lengths, so every lane count is tried in every phase against the sampled data lines.

// File: rtl/xip_seq_pkg.sv
package xip_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CMD  = 3'd1,
        PH_ADDR = 3'd2,
        PH_MODE = 3'd3,
        PH_DATA = 3'd4,
        PH_DONE = 3'd5
    } phase_e;

    typedef logic [1:0] lane_sel_t;

    localparam int CMD_CLKS = 8;

    typedef struct packed {
        logic [31:0] faddr;
        logic [2:0]  nbytes;
    } xfer_t;

    // log2 of the number of active lines
    function automatic logic [1:0] lane_log2(input lane_sel_t w);
        case (w)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input lane_sel_t w);
        case (w)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // top bits of a left-aligned shift word, placed on the low lines
    function automatic logic [3:0] top_lanes(input logic [31:0] v, input lane_sel_t w);
        case (w)
            2'd0:    return {3'b000, v[31]};
            2'd1:    return {2'b00, v[31:30]};
            default: return v[31:28];
        endcase
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] s);
        case (s)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/xip_win_map.sv
module xip_win_map #(
    parameter logic [31:0] WIN_BASE = 32'h0008_0000,
    parameter int          WIN_LOG2 = 20
) (
    input  logic [31:0] bus_addr,
    input  logic [31:0] remap_base,
    output logic        hit,
    output logic [31:0] flash_addr
);
    localparam logic [32:0] WIN_END = {1'b0, WIN_BASE} + (33'd1 << WIN_LOG2);

    logic [WIN_LOG2-1:0] offset;

    always_comb begin
        offset     = WIN_LOG2'(bus_addr - WIN_BASE);
        hit        = ({1'b0, bus_addr} >= {1'b0, WIN_BASE}) && ({1'b0, bus_addr} < WIN_END);
        flash_addr = remap_base + {{(32-WIN_LOG2){1'b0}}, offset};
    end
endmodule

// File: rtl/xip_phase_fsm.sv
module xip_phase_fsm
    import xip_seq_pkg::*;
#(
    parameter int MODE_CLK_W = 4,
    parameter int CNT_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  skip_cmd,
    input  logic                  addr4,
    input  lane_sel_t             addr_w,
    input  lane_sel_t             data_w,
    input  logic [MODE_CLK_W-1:0] mode_clks,
    input  logic [2:0]            nbytes,
    output phase_e                phase,
    output phase_e                phase_nxt,
    output logic [CNT_W-1:0]      cnt,
    output logic                  last
);
    logic [CNT_W-1:0] len;

    always_comb begin
        case (phase)
            PH_CMD:  len = CNT_W'(CMD_CLKS);
            PH_ADDR: len = CNT_W'(addr4 ? 32 : 24) >> lane_log2(addr_w);
            PH_MODE: len = CNT_W'(mode_clks);
            PH_DATA: len = CNT_W'({nbytes, 3'b000}) >> lane_log2(data_w);
            default: len = CNT_W'(1);
        endcase
        last = (cnt == len - 1'b1);
    end

    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_IDLE: if (start) phase_nxt = skip_cmd ? PH_ADDR : PH_CMD;
            PH_CMD:  if (last)  phase_nxt = PH_ADDR;
            PH_ADDR: if (last)  phase_nxt = (mode_clks != '0) ? PH_MODE : PH_DATA;
            PH_MODE: if (last)  phase_nxt = PH_DATA;
            PH_DATA: if (last)  phase_nxt = PH_DONE;
            PH_DONE:            phase_nxt = PH_IDLE;
            default:            phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_nxt;
            cnt   <= (phase_nxt != phase) ? '0 : cnt + 1'b1;
        end
    end

    // R3: the command byte is always followed by the address phase
    assert_cmd_then_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD && last) |=> (phase == PH_ADDR));

    // R11: the clock counter never runs past the length of its phase
    assert_cnt_in_phase_R11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD || phase == PH_ADDR || phase == PH_MODE || phase == PH_DATA)
            |-> (cnt < len));
endmodule

// File: rtl/xip_rx_pack.sv
module xip_rx_pack
    import xip_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        shift_en,
    input  lane_sel_t   lanes,
    input  logic [3:0]  din,
    input  logic [2:0]  nbytes,
    output logic [31:0] word
);
    logic [31:0] sh;
    logic [3:0]  bits;

    always_comb begin
        case (lanes)
            2'd0:    bits = {3'b000, din[1]};
            2'd1:    bits = {2'b00, din[1:0]};
            default: bits = din;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            sh <= '0;
        else if (shift_en)
            sh <= (sh << (3'd1 << lane_log2(lanes))) | {28'd0, bits};
    end

    // earliest byte sits highest in the shifter; place it in the low byte
    always_comb begin
        word = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(nbytes))
                word[8*k +: 8] = sh[8*(int'(nbytes) - 1 - k) +: 8];
        end
    end
endmodule

// File: rtl/xip_flash_reader.sv
module xip_flash_reader
    import xip_seq_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'h0008_0000,
    parameter int          WIN_LOG2   = 20,
    parameter int          MODE_CLK_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_enable,
    input  logic                  cfg_addr4,
    input  logic [1:0]            cfg_addr_lanes,
    input  logic [1:0]            cfg_mode_lanes,
    input  logic [1:0]            cfg_data_lanes,
    input  logic [MODE_CLK_W-1:0] cfg_mode_clks,
    input  logic                  cfg_xip_en,
    input  logic [7:0]            cfg_read_cmd,
    input  logic [7:0]            cfg_mode_enter,
    input  logic [7:0]            cfg_mode_exit,
    input  logic [31:0]           cfg_remap_base,
    input  logic                  xip_exit_req,
    input  logic                  req_valid,
    input  logic [31:0]           req_addr,
    input  logic [1:0]            req_size,
    output logic                  bus_ready,
    output logic                  rd_valid,
    output logic [31:0]           rd_data,
    output logic                  dma_req,
    output logic                  fl_cs_n,
    output logic                  fl_sck_en,
    output logic [3:0]            fl_io_out,
    output logic [3:0]            fl_io_oe,
    input  logic [3:0]            fl_io_in
);
    localparam int CNT_W = (MODE_CLK_W + 1 > 6) ? MODE_CLK_W + 1 : 6;

    logic             hit, start, serial_on, mode_full;
    logic             xip_active, term_pend, last;
    logic [31:0]      faddr_c, fa_src, sr, word;
    logic [7:0]       mode_byte;
    logic [CNT_W-1:0] cnt, mode_byte_clks;
    lane_sel_t        cur_w;
    phase_e           ph, ph_nxt;
    xfer_t            xfer_q;

    xip_win_map #(.WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) win_i (
        .bus_addr   (req_addr),
        .remap_base (cfg_remap_base),
        .hit        (hit),
        .flash_addr (faddr_c)
    );

    assign start = req_valid && cfg_enable && hit && (ph == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst)
            xfer_q <= '0;
        else if (start)
            xfer_q <= '{faddr: faddr_c, nbytes: size_bytes(req_size)};
    end

    xip_phase_fsm #(.MODE_CLK_W(MODE_CLK_W), .CNT_W(CNT_W)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .skip_cmd  (xip_active),
        .addr4     (cfg_addr4),
        .addr_w    (cfg_addr_lanes),
        .data_w    (cfg_data_lanes),
        .mode_clks (cfg_mode_clks),
        .nbytes    (start ? size_bytes(req_size) : xfer_q.nbytes),
        .phase     (ph),
        .phase_nxt (ph_nxt),
        .cnt       (cnt),
        .last      (last)
    );

    // phase-dependent lane selection and mode byte
    always_comb begin
        serial_on = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_MODE) || (ph == PH_DATA);
        case (ph)
            PH_ADDR: cur_w = cfg_addr_lanes;
            PH_MODE: cur_w = cfg_mode_lanes;
            PH_DATA: cur_w = cfg_data_lanes;
            default: cur_w = 2'd0;
        endcase
        mode_byte      = (cfg_xip_en && !term_pend) ? cfg_mode_enter : cfg_mode_exit;
        mode_byte_clks = CNT_W'(8) >> lane_log2(cfg_mode_lanes);
        mode_full      = (int'(cfg_mode_clks) << lane_log2(cfg_mode_lanes)) >= 8;
        fa_src         = (ph == PH_IDLE) ? faddr_c : xfer_q.faddr;
    end

    // transmit shifter: loaded on phase entry, shifted once per serial clock
    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (ph_nxt != ph) begin
            case (ph_nxt)
                PH_CMD:  sr <= {cfg_read_cmd, 24'd0};
                PH_ADDR: sr <= cfg_addr4 ? fa_src : {fa_src[23:0], 8'd0};
                PH_MODE: sr <= {mode_byte, 24'd0};
                default: sr <= '0;
            endcase
        end else if (serial_on) begin
            sr <= sr << (3'd1 << lane_log2(cur_w));
        end
    end

    // continuous-read state
    always_ff @(posedge clk) begin
        if (rst || !cfg_enable) begin
            xip_active <= 1'b0;
            term_pend  <= 1'b0;
        end else begin
            if (ph == PH_MODE && last && mode_full) begin
                xip_active <= cfg_xip_en && !term_pend;
                term_pend  <= 1'b0;
            end
            if (xip_exit_req)
                term_pend <= 1'b1;
        end
    end

    always_comb begin
        case (ph)
            PH_CMD:  fl_io_oe = 4'b0001;
            PH_ADDR: fl_io_oe = lane_mask(cfg_addr_lanes);
            PH_MODE: fl_io_oe = (cnt < mode_byte_clks) ? lane_mask(cfg_mode_lanes) : 4'b0000;
            default: fl_io_oe = 4'b0000;
        endcase
        fl_io_out = top_lanes(sr, cur_w) & fl_io_oe;
        fl_cs_n   = !serial_on;
        fl_sck_en = serial_on;
    end

    xip_rx_pack rx_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .shift_en (ph == PH_DATA),
        .lanes    (cfg_data_lanes),
        .din      (fl_io_in),
        .nbytes   (xfer_q.nbytes),
        .word     (word)
    );

    assign bus_ready = (ph == PH_IDLE);
    assign rd_valid  = (ph == PH_DONE);
    assign rd_data   = rd_valid ? word : 32'd0;
    assign dma_req   = rd_valid && (xfer_q.nbytes == 3'd4);

    // R1: a flash sequence only ever opens right after a bus request
    assert_open_after_req_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_cs_n) |-> $past(req_valid));

    // R9: the result strobe is followed by an idle, ready cycle
    assert_done_then_ready_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> (bus_ready && fl_cs_n && !rd_valid));

    // R10: the DMA pulse never comes without the result strobe
    assert_dma_with_result_R10: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> rd_valid);

    // R8: a single-byte result carries zeros above its low byte
    assert_byte_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && xfer_q.nbytes == 3'd1) |-> (rd_data[31:8] == 24'd0));

    // R6: continuous-read state is only entered at the end of a mode phase
    assert_xip_from_mode_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(xip_active) |-> $past(ph == PH_MODE));

    // R6: while continuous read holds, a new sequence opens on the address phase
    assert_xip_skips_cmd_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(fl_cs_n) && xip_active) |-> (ph == PH_ADDR));
endmodule

// File: tb/xip_flash_reader_tb_top.sv
module xip_flash_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_enable, cfg_addr4, cfg_xip_en;
    logic [1:0]  cfg_addr_lanes, cfg_mode_lanes, cfg_data_lanes;
    logic [3:0]  cfg_mode_clks;
    logic [7:0]  cfg_read_cmd, cfg_mode_enter, cfg_mode_exit;
    logic [31:0] cfg_remap_base;
    logic        xip_exit_req, req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        bus_ready, rd_valid, dma_req, fl_cs_n, fl_sck_en;
    logic [31:0] rd_data;
    logic [3:0]  fl_io_out, fl_io_oe, fl_io_in;

    int compared = 0;
    int failed   = 0;

    // reference model state
    bit m_xip  = 0;
    bit m_term = 0;

    always #10 clk = ~clk;

    xip_flash_reader dut_i (
        .clk(clk), .rst(rst),
        .cfg_enable(cfg_enable), .cfg_addr4(cfg_addr4),
        .cfg_addr_lanes(cfg_addr_lanes), .cfg_mode_lanes(cfg_mode_lanes),
        .cfg_data_lanes(cfg_data_lanes), .cfg_mode_clks(cfg_mode_clks),
        .cfg_xip_en(cfg_xip_en), .cfg_read_cmd(cfg_read_cmd),
        .cfg_mode_enter(cfg_mode_enter), .cfg_mode_exit(cfg_mode_exit),
        .cfg_remap_base(cfg_remap_base), .xip_exit_req(xip_exit_req),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .bus_ready(bus_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .dma_req(dma_req), .fl_cs_n(fl_cs_n), .fl_sck_en(fl_sck_en),
        .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
    );

    function automatic int lanes_of(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [3:0] mask_of(input int n);
        return 4'((1 << n) - 1);
    endfunction

    // content of the modelled flash
    function automatic logic [7:0] flash_byte(input logic [31:0] a);
        return (a[7:0] ^ a[15:8] ^ a[23:16]) + 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one serial clock: compare outputs, drive flash data, move to next cycle
    task automatic step(input logic [3:0] eoe, input logic [3:0] edo, input logic [3:0] din_v, input string tag);
        compared++;
        if (fl_cs_n !== 1'b0 || fl_sck_en !== 1'b1 || fl_io_oe !== eoe ||
            (fl_io_out & eoe) !== (edo & eoe) || bus_ready !== 1'b0 || rd_valid !== 1'b0) begin
            failed++;
            $display("FAIL %s: actual cs_n=%b sck=%b oe=%h out=%h rdy=%b expected cs_n=0 sck=1 oe=%h out=%h rdy=0",
                     tag, fl_cs_n, fl_sck_en, fl_io_oe, fl_io_out, bus_ready, eoe, edo & eoe);
        end
        fl_io_in = din_v;
        @(negedge clk);
    endtask

    // entered and left at a falling edge
    task automatic bus_read(input logic [31:0] a, input logic [1:0] sz, input bit hold);
        logic [31:0] fa, v, exp_word;
        int la, lm, ld, nb, nclk;
        bit inwin;
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        inwin = (a >= 32'h0008_0000) && (a < 32'h0018_0000);
        if (!(inwin && cfg_enable)) begin
            req_valid = 1'b0;
            for (int i = 0; i < 3; i++) begin
                chk(fl_cs_n === 1'b1 && bus_ready === 1'b1 && rd_valid === 1'b0, "R1 ignored request",
                    {30'd0, fl_cs_n, bus_ready}, 32'd3);
                @(negedge clk);
            end
            return;
        end
        fa = cfg_remap_base + ((a - 32'h0008_0000) & 32'h000F_FFFF);
        if (!m_xip)
            for (int i = 0; i < 8; i++)
                step(4'b0001, {3'b000, cfg_read_cmd[7-i]}, 4'h0, "R3 command");
        la = lanes_of(cfg_addr_lanes);
        v  = cfg_addr4 ? fa : {fa[23:0], 8'h00};
        nclk = (cfg_addr4 ? 32 : 24) / la;
        for (int i = 0; i < nclk; i++) begin
            step(mask_of(la), 4'(v >> (32 - la)), 4'h0, "R2 R4 address");
            v = v << la;
        end
        lm = lanes_of(cfg_mode_lanes);
        v  = {((cfg_xip_en && !m_term) ? cfg_mode_enter : cfg_mode_exit), 24'd0};
        for (int i = 0; i < int'(cfg_mode_clks); i++) begin
            if (i < 8 / lm) begin
                step(mask_of(lm), 4'(v >> (32 - lm)), 4'h0, "R5 R6 mode byte");
                v = v << lm;
            end else begin
                step(4'b0000, 4'h0, 4'h0, "R5 dummy");
            end
        end
        if (int'(cfg_mode_clks) * lm >= 8) begin
            m_xip  = cfg_xip_en && !m_term;
            m_term = 0;
        end
        ld = lanes_of(cfg_data_lanes);
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        exp_word = 32'd0;
        for (int k = 0; k < nb; k++) begin
            logic [7:0] fb;
            fb = flash_byte(fa + 32'(k));
            exp_word[8*k +: 8] = fb;
            for (int c = 0; c < 8 / ld; c++) begin
                logic [3:0] chunk, dv;
                chunk = 4'((fb >> (8 - ld * (c + 1))) & 8'(mask_of(ld)));
                if (ld == 1)      dv = {2'b11, chunk[0], 1'b1};
                else if (ld == 2) dv = {2'b11, chunk[1:0]};
                else              dv = chunk;
                step(4'b0000, 4'h0, dv, "R8 data");
            end
        end
        fl_io_in = 4'h0;
        chk(rd_valid === 1'b1 && fl_cs_n === 1'b1 && bus_ready === 1'b0 && fl_sck_en === 1'b0,
            "R9 R11 completion", {28'd0, rd_valid, fl_cs_n, bus_ready, fl_sck_en}, 32'b1100);
        chk(rd_data === exp_word, "R8 result", rd_data, exp_word);
        chk(dma_req === (nb == 4), "R10 dma", {31'd0, dma_req}, {31'd0, nb == 4});
        req_valid = 1'b0;
        @(negedge clk);
        chk(bus_ready === 1'b1 && fl_cs_n === 1'b1 && rd_valid === 1'b0 && dma_req === 1'b0,
            "R9 back to idle", {29'd0, bus_ready, fl_cs_n, rd_valid}, 32'b110);
    endtask

    task automatic exit_pulse();
        xip_exit_req = 1'b1;
        @(negedge clk);
        xip_exit_req = 1'b0;
        if (cfg_enable) m_term = 1;
    endtask

    task automatic set_cfg(input logic [1:0] aw, input logic [1:0] mw, input logic [1:0] dw,
                           input logic [3:0] mclk, input bit a4, input bit xen);
        cfg_addr_lanes = aw;
        cfg_mode_lanes = mw;
        cfg_data_lanes = dw;
        cfg_mode_clks  = mclk;
        cfg_addr4      = a4;
        cfg_xip_en     = xen;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_enable = 1'b1;
        set_cfg(2'd0, 2'd0, 2'd0, 4'd0, 1'b0, 1'b0);
        cfg_read_cmd   = 8'h03;
        cfg_mode_enter = 8'hA5;
        cfg_mode_exit  = 8'hF0;
        cfg_remap_base = 32'h0;
        xip_exit_req   = 1'b0;
        req_valid      = 1'b0;
        req_addr       = 32'h0;
        req_size       = 2'd0;
        fl_io_in       = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R9, R11)
        chk(bus_ready === 1'b1 && fl_cs_n === 1'b1 && fl_sck_en === 1'b0 && rd_valid === 1'b0 &&
            dma_req === 1'b0 && fl_io_oe === 4'h0, "R9 R11 reset state",
            {26'd0, bus_ready, fl_cs_n, fl_sck_en, rd_valid, dma_req, |fl_io_oe}, 32'b110000);

        // plain single-line reads, 3-byte address, no mode phase
        bus_read(32'h0008_0000, 2'd0, 0);
        bus_read(32'h0008_0123, 2'd1, 0);

        // dual lanes, 4-byte address, remap, mode byte fits exactly: enters continuous read (R6)
        set_cfg(2'd1, 2'd1, 2'd1, 4'd4, 1'b1, 1'b1);
        cfg_read_cmd   = 8'hBB;
        cfg_remap_base = 32'h0100_0000;
        bus_read(32'h0008_0010, 2'd2, 0);
        bus_read(32'h0017_FFFC, 2'd2, 1);   // R9: request held through the sequence
        bus_read(32'h0017_FFFF, 2'd0, 0);

        // quad lanes, mode byte plus dummy clocks (R5)
        set_cfg(2'd2, 2'd3, 2'd2, 4'd6, 1'b0, 1'b1);
        cfg_read_cmd = 8'hEB;
        bus_read(32'h0009_2345, 2'd2, 0);
        bus_read(32'h0009_2346, 2'd1, 0);

        // terminate: exit byte next, then the command returns (R7)
        exit_pulse();
        bus_read(32'h000A_0000, 2'd1, 0);
        bus_read(32'h000A_0004, 2'd0, 0);
        bus_read(32'h000A_0008, 2'd2, 0);

        // out-of-window addresses (R1)
        bus_read(32'h0007_FFFF, 2'd2, 0);
        bus_read(32'h0018_0000, 2'd2, 0);

        // disabled: ignored, and continuous read is cleared (R1, R3)
        cfg_enable = 1'b0;
        @(negedge clk);
        m_xip = 0;
        m_term = 0;
        bus_read(32'h0008_0040, 2'd0, 0);
        cfg_enable = 1'b1;
        bus_read(32'h0008_0040, 2'd0, 0);
        bus_read(32'h0008_0044, 2'd1, 0);

        // mixed lanes: single address, quad mode, single data
        set_cfg(2'd0, 2'd2, 2'd0, 4'd2, 1'b1, 1'b1);
        bus_read(32'h000C_1230, 2'd2, 0);
        bus_read(32'h000C_1234, 2'd0, 0);

        // exit byte selected by cfg_xip_en=0 leaves continuous read (R6)
        set_cfg(2'd1, 2'd0, 2'd2, 4'd8, 1'b0, 1'b0);
        bus_read(32'h000D_0000, 2'd1, 0);
        bus_read(32'h000D_0002, 2'd1, 0);

        // mode byte cut short: continuous read is never entered (R6 boundary)
        set_cfg(2'd2, 2'd0, 2'd1, 4'd4, 1'b0, 1'b1);
        bus_read(32'h000E_0000, 2'd2, 0);
        bus_read(32'h000E_0004, 2'd0, 0);

        // mode phase skipped entirely (R5)
        set_cfg(2'd1, 2'd1, 2'd2, 4'd0, 1'b1, 1'b1);
        bus_read(32'h000F_0000, 2'd2, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
        $finish;
    end
endmodule